// File: doc/BRIEF.md
# Multi-song melody player

This block plays one of eight built-in tunes on a buzzer. A single fast system clock (50 MHz by default) is divided twice. The first stage gives a microsecond tick. The second stage gives a score step every quarter second. On each step the sequencer moves to the next position of the selected tune, reads a 5-bit note code and turns it into a divider count for the microsecond tick. A tone generator reloads a down-counter with that count and emits a one-tick pulse on every reload. A toggle stage halves that pulse rate into a square wave on `tone_out`. A seven-segment digit with active-low segments shows the number of the tune being played, or a zero when idle.

The player is controlled by three inputs. `start_n` low is an asynchronous clear. `enable` low mutes the output and puts the display in its idle glyph. `song_sel` chooses the tune. Any change of `song_sel` restarts the chosen tune from position zero with fresh divider phases.

The sequencer has three states. P_IDLE is entered from any state when `enable` is low, and it is the reset state. When `enable` is high, P_IDLE goes to P_SOUND if the note code is pitched and to P_REST if it is a rest. At each note start (a step or a restart), P_SOUND goes to P_REST when the new note is a rest. At each note start, P_REST goes to P_SOUND when the new note is pitched. In every other case the state holds.

Top module: `mel_player`

## Requirements
- R1: While `start_n` is low, and right after it, `tone_out` is 0 and `seg_n` shows the idle glyph 7'b1000000.
- R2: Step boundaries fall every CLK_DIV*STEP_DIV clocks, counted from the clock edge that restarts the tune. Counted from each note's start edge, `tone_out` is still 0 after edge CLK_DIV and becomes 1 after edge CLK_DIV+1.
- R3: A pitched note with divider D holds `tone_out` high for (D+1)*CLK_DIV clocks per half period. The dividers for degrees 1 to 7 are 3823, 3405, 3034, 2863, 2551, 2273, 2025 in octave 0 (low); 1911, 1703, 1517, 1432, 1276, 1137, 1012 in octave 1 (mid); and 956, 851, 758, 716, 638, 568, 506 in octave 2 (high).
- R4: A note code whose degree is 0, or whose octave field is 3, is a rest. `tone_out` stays 0 for the whole of that step.
- R5: The note code is {octave[1:0], degree[2:0]}. In the built-in tunes, tune s (the `song_sel` value) has octave = p mod 3 and degree = (p + s) mod 8 at position p.
- R6: Each tune has 57 positions, 0 to 56. After position 56 the next step plays position 0.
- R7: When `song_sel` differs from its value at the previous clock edge, that edge sets the position to 0 and clears both divider stages. If the same edge would also end a step, the restart wins.
- R8: With `enable` low, `tone_out` is 0 in the same cycle and the display turns idle at the next edge. The score position keeps advancing while `enable` is low.
- R9: `seg_n` = {g,f,e,d,c,b,a} with 0 = segment lit. While playing, it shows digit s+1. The glyphs are: 0 = 1000000, 1 = 1111001, 2 = 0100100, 3 = 0110000, 4 = 0011001, 5 = 0010010, 6 = 0000010, 7 = 1111000, 8 = 0000000.
- R10: Pulling `start_n` low silences `tone_out` at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| start_n | input | 1 | Active-low asynchronous clear of all counters and state |
| enable | input | 1 | High to play; low mutes the output and shows the idle digit |
| song_sel | input | 3 | Tune number 0 to 7; a change restarts the tune |
| tone_out | output | 1 | Square-wave audio output |
| seg_n | output | 7 | Active-low segments {g,f,e,d,c,b,a} showing the tune number |

## Verification
A select change and the end of a step can land on the same clock edge. The bench provokes this on a short-step instance. It restarts a tune, counts edges to a known step boundary, and changes the select just before that edge. The result is judged by the sound/rest pattern of the following steps. It must match the new tune from position 0; a pattern shifted by one step shows that the step advance won over the restart.

// File: rtl/mel_pkg.sv
package mel_pkg;

    localparam int SONG_W = 3;
    localparam int DIV_W  = 12;
    localparam int SEG_W  = 7;

    typedef enum logic [1:0] {
        P_IDLE  = 2'd0,
        P_SOUND = 2'd1,
        P_REST  = 2'd2
    } play_state_t;

    typedef struct packed {
        logic [1:0] oct;
        logic [2:0] deg;
    } note_t;

    // Built-in test tunes: octave walks low/mid/high, degree offset by tune.
    function automatic note_t score_note(input logic [SONG_W-1:0] song,
                                         input int unsigned       pos);
        note_t n;
        n.oct = 2'(pos % 3);
        n.deg = 3'((pos + int'(song)) % 8);
        return n;
    endfunction

    // Divider for the microsecond tick; zero means rest.
    function automatic logic [DIV_W-1:0] note_div(input note_t n);
        logic [DIV_W-1:0] d;
        d = '0;
        unique case (n.oct)
            2'd0: begin
                unique case (n.deg)
                    3'd1: d = 12'd3823;
                    3'd2: d = 12'd3405;
                    3'd3: d = 12'd3034;
                    3'd4: d = 12'd2863;
                    3'd5: d = 12'd2551;
                    3'd6: d = 12'd2273;
                    3'd7: d = 12'd2025;
                    default: d = '0;
                endcase
            end
            2'd1: begin
                unique case (n.deg)
                    3'd1: d = 12'd1911;
                    3'd2: d = 12'd1703;
                    3'd3: d = 12'd1517;
                    3'd4: d = 12'd1432;
                    3'd5: d = 12'd1276;
                    3'd6: d = 12'd1137;
                    3'd7: d = 12'd1012;
                    default: d = '0;
                endcase
            end
            2'd2: begin
                unique case (n.deg)
                    3'd1: d = 12'd956;
                    3'd2: d = 12'd851;
                    3'd3: d = 12'd758;
                    3'd4: d = 12'd716;
                    3'd5: d = 12'd638;
                    3'd6: d = 12'd568;
                    3'd7: d = 12'd506;
                    default: d = '0;
                endcase
            end
            default: d = '0;
        endcase
        return d;
    endfunction

    // Active-low glyph, bit order {g,f,e,d,c,b,a}.
    function automatic logic [SEG_W-1:0] digit_glyph(input logic [3:0] v);
        logic [SEG_W-1:0] g;
        unique case (v)
            4'd0: g = 7'b1000000;
            4'd1: g = 7'b1111001;
            4'd2: g = 7'b0100100;
            4'd3: g = 7'b0110000;
            4'd4: g = 7'b0011001;
            4'd5: g = 7'b0010010;
            4'd6: g = 7'b0000010;
            4'd7: g = 7'b1111000;
            4'd8: g = 7'b0000000;
            default: g = 7'b1111111;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/mel_tick_gen.sv
module mel_tick_gen #(
    parameter int CLK_DIV  = 50,
    parameter int STEP_DIV = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic us_tick,
    output logic step_tick
);
    localparam int PRE_W  = (CLK_DIV  > 1) ? $clog2(CLK_DIV)  : 1;
    localparam int STEP_W = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;
    localparam logic [PRE_W-1:0]  PRE_LAST  = PRE_W'(CLK_DIV - 1);
    localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEP_DIV - 1);

    logic [PRE_W-1:0]  pre_q;
    logic [STEP_W-1:0] step_q;

    assign us_tick   = (pre_q == PRE_LAST);
    assign step_tick = us_tick && (step_q == STEP_LAST);

    // First stage: system clock down to the microsecond tick.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (restart || us_tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // Second stage: microsecond tick down to the score step.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q <= '0;
        end else if (restart || step_tick) begin
            step_q <= '0;
        end else if (us_tick) begin
            step_q <= step_q + 1'b1;
        end
    end

endmodule

// File: rtl/mel_score_seq.sv
module mel_score_seq
    import mel_pkg::*;
#(
    parameter int STEPS = 57,
    parameter int POS_W = $clog2(STEPS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic [SONG_W-1:0]    song_sel,
    input  logic                 step_tick,
    output logic                 restart,
    output logic                 note_start,
    output logic [POS_W-1:0]     pos,
    output logic [SONG_W-1:0]    song,
    output logic [DIV_W-1:0]     div,
    output play_state_t          state
);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(STEPS - 1);

    logic [SONG_W-1:0] sel_q;
    logic [POS_W-1:0]  pos_q;
    logic [POS_W-1:0]  pos_d;
    logic [DIV_W-1:0]  div_q;
    logic [DIV_W-1:0]  div_d;
    logic              rest_d;
    play_state_t       state_q;
    play_state_t       state_d;

    assign restart    = (song_sel != sel_q);
    assign note_start = restart || step_tick;

    // Position of the note that the next edge will play; restart has priority.
    always_comb begin
        if (restart) begin
            pos_d = '0;
        end else if (step_tick) begin
            pos_d = (pos_q == POS_LAST) ? '0 : pos_q + 1'b1;
        end else begin
            pos_d = pos_q;
        end
        div_d  = note_div(score_note(song_sel, int'(pos_d)));
        rest_d = (div_d == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
            pos_q <= '0;
            div_q <= '0;
        end else begin
            sel_q <= song_sel;
            pos_q <= pos_d;
            div_q <= div_d;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= P_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            P_IDLE: begin
                if (enable) begin
                    state_d = rest_d ? P_REST : P_SOUND;
                end
            end
            P_SOUND: begin
                if (!enable) begin
                    state_d = P_IDLE;
                end else if (note_start && rest_d) begin
                    state_d = P_REST;
                end
            end
            P_REST: begin
                if (!enable) begin
                    state_d = P_IDLE;
                end else if (note_start && !rest_d) begin
                    state_d = P_SOUND;
                end
            end
            default: state_d = P_IDLE;
        endcase
    end

    assign pos   = pos_q;
    assign song  = sel_q;
    assign div   = div_q;
    assign state = state_q;

endmodule

// File: rtl/mel_tone_gen.sv
module mel_tone_gen
    import mel_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             sounding,
    input  logic             note_start,
    input  logic             us_tick,
    input  logic [DIV_W-1:0] div,
    output logic             pulse,
    output logic             tog
);
    logic [DIV_W-1:0] cnt_q;
    logic             pulse_q;
    logic             tog_q;
    logic             hold;

    assign hold = note_start || !enable || !sounding;

    // Reload pulse, then toggle on the pulse; every note starts in phase.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            pulse_q <= 1'b0;
            tog_q   <= 1'b0;
        end else if (hold) begin
            cnt_q   <= '0;
            pulse_q <= 1'b0;
            tog_q   <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (us_tick) begin
                if (cnt_q == '0) begin
                    cnt_q   <= div;
                    pulse_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
            if (pulse_q) begin
                tog_q <= ~tog_q;
            end
        end
    end

    assign pulse = pulse_q;
    assign tog   = tog_q;

endmodule

// File: rtl/mel_seg_disp.sv
module mel_seg_disp
    import mel_pkg::*;
(
    input  play_state_t       state,
    input  logic [SONG_W-1:0] song,
    output logic [SEG_W-1:0]  seg_n
);
    // Output decode from the sequencer state.
    always_comb begin
        unique case (state)
            P_SOUND, P_REST: seg_n = digit_glyph(4'(song) + 4'd1);
            P_IDLE:          seg_n = digit_glyph(4'd0);
            default:         seg_n = digit_glyph(4'd0);
        endcase
    end

endmodule

// File: rtl/mel_player.sv
module mel_player
    import mel_pkg::*;
#(
    parameter int CLK_DIV  = 50,
    parameter int STEP_DIV = 250000,
    parameter int STEPS    = 57
) (
    input  logic              clk,
    input  logic              start_n,
    input  logic              enable,
    input  logic [SONG_W-1:0] song_sel,
    output logic              tone_out,
    output logic [SEG_W-1:0]  seg_n
);
    localparam int POS_W = $clog2(STEPS);

    logic             us_tick_w;
    logic             step_tick_w;
    logic             restart_w;
    logic             note_start_w;
    logic [POS_W-1:0] pos_w;
    logic [SONG_W-1:0] song_w;
    logic [DIV_W-1:0] div_w;
    play_state_t      state_w;
    logic             pulse_w;
    logic             tog_w;

    mel_tick_gen #(
        .CLK_DIV  (CLK_DIV),
        .STEP_DIV (STEP_DIV)
    ) u_tick (
        .clk       (clk),
        .rst_n     (start_n),
        .restart   (restart_w),
        .us_tick   (us_tick_w),
        .step_tick (step_tick_w)
    );

    mel_score_seq #(
        .STEPS (STEPS),
        .POS_W (POS_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (start_n),
        .enable     (enable),
        .song_sel   (song_sel),
        .step_tick  (step_tick_w),
        .restart    (restart_w),
        .note_start (note_start_w),
        .pos        (pos_w),
        .song       (song_w),
        .div        (div_w),
        .state      (state_w)
    );

    mel_tone_gen u_tone (
        .clk        (clk),
        .rst_n      (start_n),
        .enable     (enable),
        .sounding   (state_w == P_SOUND),
        .note_start (note_start_w),
        .us_tick    (us_tick_w),
        .div        (div_w),
        .pulse      (pulse_w),
        .tog        (tog_w)
    );

    mel_seg_disp u_disp (
        .state (state_w),
        .song  (song_w),
        .seg_n (seg_n)
    );

    assign tone_out = tog_w && enable;

endmodule

// File: rtl/mel_player_chk.sv
module mel_player_chk
    import mel_pkg::*;
#(
    parameter int STEPS = 57,
    parameter int POS_W = $clog2(STEPS)
) (
    input logic              clk,
    input logic              start_n,
    input logic [SONG_W-1:0] song_sel,
    input logic              tone_out,
    input logic [SEG_W-1:0]  seg_n,
    input logic [POS_W-1:0]  pos,
    input play_state_t       state,
    input logic              us_tick,
    input logic              step_tick,
    input logic              pulse,
    input logic              tog
);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(STEPS - 1);

    a_r2_step_on_tick: assert property (@(posedge clk) disable iff (!start_n)
        step_tick |-> us_tick);

    a_r6_pos_in_range: assert property (@(posedge clk) disable iff (!start_n)
        pos <= POS_LAST);

    a_r6_advance_wrap: assert property (@(posedge clk) disable iff (!start_n)
        (step_tick && song_sel == $past(song_sel)) |=>
        (pos == (($past(pos) == POS_LAST) ? '0 : $past(pos) + 1'b1)));

    a_r7_restart_zero: assert property (@(posedge clk) disable iff (!start_n)
        (song_sel != $past(song_sel)) |=> (pos == '0));

    a_r4_rest_quiet: assert property (@(posedge clk) disable iff (!start_n)
        (state == P_REST) |-> !tone_out);

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!start_n)
        (state == P_IDLE) |-> !tone_out);

    a_r3_toggle_after_pulse: assert property (@(posedge clk) disable iff (!start_n)
        $rose(tog) |-> $past(pulse));

    a_r3_pulse_on_tick: assert property (@(posedge clk) disable iff (!start_n)
        $rose(pulse) |-> $past(us_tick));

    a_r9_idle_glyph: assert property (@(posedge clk) disable iff (!start_n)
        (state == P_IDLE) |-> (seg_n == 7'b1000000));

endmodule

bind mel_player mel_player_chk #(
    .STEPS (STEPS)
) u_chk (
    .clk       (clk),
    .start_n   (start_n),
    .song_sel  (song_sel),
    .tone_out  (tone_out),
    .seg_n     (seg_n),
    .pos       (pos_w),
    .state     (state_w),
    .us_tick   (us_tick_w),
    .step_tick (step_tick_w),
    .pulse     (pulse_w),
    .tog       (tog_w)
);

// File: tb/sim_mel_player.sv
module sim_mel_player;

    localparam int CDIV   = 2;
    localparam int LONG   = 4000;
    localparam int SHORT  = 8;
    localparam int LSTEP  = CDIV * LONG;
    localparam int SSTEP  = CDIV * SHORT;
    localparam int NSTEPS = 57;

    logic       clk = 1'b0;
    logic       start_n = 1'b0;
    logic       en0 = 1'b1;
    logic       en1 = 1'b1;
    logic [2:0] sel0 = 3'd0;
    logic [2:0] sel1 = 3'd0;
    logic       tone0;
    logic       tone1;
    logic [6:0] seg0;
    logic [6:0] seg1;

    int checks = 0;
    int fails  = 0;
    int ncyc   = 0;
    int e0     = 0;
    int e1     = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) ncyc <= ncyc + 1;

    mel_player #(.CLK_DIV(CDIV), .STEP_DIV(LONG), .STEPS(NSTEPS)) u0 (
        .clk(clk), .start_n(start_n), .enable(en0), .song_sel(sel0),
        .tone_out(tone0), .seg_n(seg0));

    mel_player #(.CLK_DIV(CDIV), .STEP_DIV(SHORT), .STEPS(NSTEPS)) u1 (
        .clk(clk), .start_n(start_n), .enable(en1), .song_sel(sel1),
        .tone_out(tone1), .seg_n(seg1));

    // Expected values from the requirements.
    function automatic int exp_deg(input int s, input int p);
        return (p + s) % 8;
    endfunction

    function automatic int exp_div(input int s, input int p);
        int o = p % 3;
        int d = exp_deg(s, p);
        int lo[7] = '{3823, 3405, 3034, 2863, 2551, 2273, 2025};
        int mi[7] = '{1911, 1703, 1517, 1432, 1276, 1137, 1012};
        int hi[7] = '{956, 851, 758, 716, 638, 568, 506};
        if (d == 0) return 0;
        if (o == 0) return lo[d-1];
        if (o == 1) return mi[d-1];
        return hi[d-1];
    endfunction

    function automatic logic [6:0] glyph(input int v);
        logic [6:0] t[9] = '{7'b1000000, 7'b1111001, 7'b0100100, 7'b0110000,
                             7'b0011001, 7'b0010010, 7'b0000010, 7'b1111000,
                             7'b0000000};
        return t[v];
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d at edge %0d", req, act, exp, ncyc);
        end
    endtask

    task automatic at_edge(input int n);
        while (ncyc < n) @(negedge clk);
    endtask

    task automatic restart0(input logic [2:0] s);
        @(negedge clk);
        sel0 = s;
        @(negedge clk);
        e0 = ncyc;
    endtask

    task automatic restart1(input logic [2:0] s);
        @(negedge clk);
        sel1 = s;
        @(negedge clk);
        e1 = ncyc;
    endtask

    // R1: state under and right after reset.
    task automatic t_reset();
        start_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(tone0 == 1'b0, "R1 tone0 in reset", tone0, 0);
        chk(tone1 == 1'b0, "R1 tone1 in reset", tone1, 0);
        chk(seg0 == 7'b1000000, "R1 seg0 idle in reset", seg0, 7'b1000000);
        chk(seg1 == 7'b1000000, "R1 seg1 idle in reset", seg1, 7'b1000000);
        start_n = 1'b1;
        @(negedge clk);
        chk(tone0 == 1'b0, "R1 tone0 after release", tone0, 0);
        chk(seg0 == glyph(1), "R9 seg0 tune 0 after release", seg0, glyph(1));
    endtask

    // R2 and R3: first-pulse timing and high time of three notes per tune.
    task automatic t_tone(input int s);
        restart0(3'(s));
        chk(seg0 == glyph(s + 1), "R9 seg0 digit", seg0, glyph(s + 1));
        for (int k = 0; k < 3; k++) begin
            int b = e0 + k * LSTEP;
            int d = exp_div(s, k);
            int h = 0;
            at_edge(b + CDIV);
            chk(tone0 == 1'b0, "R2 tone low before first flip", tone0, 0);
            at_edge(b + CDIV + 1);
            chk(tone0 == 1'b1, "R2 tone high after first flip", tone0, 1);
            while (tone0 == 1'b1 && h < LSTEP) begin
                h++;
                @(negedge clk);
            end
            chk(h == (d + 1) * CDIV, "R3 high time", h, (d + 1) * CDIV);
        end
    endtask

    // R4, R5, R6: sound/rest pattern over a whole tune and the wrap.
    task automatic t_walk(input int s);
        restart1(3'(s));
        chk(seg1 == glyph(s + 1), "R9 seg1 digit", seg1, glyph(s + 1));
        for (int k = 0; k < NSTEPS + 2; k++) begin
            int p = k % NSTEPS;
            bit snd = (exp_deg(s, p) != 0);
            at_edge(e1 + k * SSTEP + SSTEP / 2);
            if (k >= NSTEPS)
                chk(tone1 == snd, "R6 wrap to position 0", tone1, snd);
            else if (!snd)
                chk(tone1 == 1'b0, "R4 rest step silent", tone1, 0);
            else
                chk(tone1 == 1'b1, "R5 pitched step sounds", tone1, 1);
        end
    endtask

    // R7: select change on the same edge as a step boundary.
    task automatic t_collide();
        int en;
        restart1(3'd3);
        at_edge(e1 + 5 * SSTEP - 1);
        sel1 = 3'd4;
        @(negedge clk);
        en = ncyc;
        chk(en == e1 + 5 * SSTEP, "R7 collision edge placement", en, e1 + 5 * SSTEP);
        chk(seg1 == glyph(5), "R7 seg1 new digit", seg1, glyph(5));
        for (int k = 0; k < 6; k++) begin
            bit snd = (exp_deg(4, k) != 0);
            at_edge(en + k * SSTEP + SSTEP / 2);
            chk(tone1 == snd, "R7 restart wins over step", tone1, snd);
        end
    endtask

    // R8: enable low mutes at once; the score keeps moving.
    task automatic t_enable();
        restart1(3'd2);
        at_edge(e1 + SSTEP / 2);
        chk(tone1 == 1'b1, "R8 sounding before mute", tone1, 1);
        en1 = 1'b0;
        #1;
        chk(tone1 == 1'b0, "R8 mute same cycle", tone1, 0);
        at_edge(e1 + SSTEP / 2 + 1);
        chk(seg1 == 7'b1000000, "R8 idle glyph while muted", seg1, 7'b1000000);
        at_edge(e1 + SSTEP + SSTEP / 2);
        chk(tone1 == 1'b0, "R8 muted pitched step", tone1, 0);
        at_edge(e1 + 2 * SSTEP + SSTEP / 2 - 1);
        en1 = 1'b1;
        at_edge(e1 + 3 * SSTEP + SSTEP / 2);
        chk(tone1 == 1'b1, "R8 resumes at position 3", tone1, 1);
        chk(seg1 == glyph(3), "R8 digit back after enable", seg1, glyph(3));
        at_edge(e1 + 6 * SSTEP + SSTEP / 2);
        chk(tone1 == 1'b0, "R8 position 6 rest proves advance", tone1, 0);
    endtask

    // R10: asynchronous clear while a tone is high.
    task automatic t_async();
        restart0(3'd6);
        at_edge(e0 + CDIV + 1);
        chk(tone0 == 1'b1, "R10 tone high before clear", tone0, 1);
        #2;
        start_n = 1'b0;
        #1;
        chk(tone0 == 1'b0, "R10 clear without clock", tone0, 0);
        chk(seg0 == 7'b1000000, "R10 idle glyph on clear", seg0, 7'b1000000);
        @(negedge clk);
        start_n = 1'b1;
        @(negedge clk);
        chk(seg0 == glyph(7), "R10 digit after release", seg0, glyph(7));
    endtask

    initial begin
        t_reset();
        t_tone(1);
        t_tone(3);
        t_tone(5);
        t_walk(2);
        t_walk(7);
        t_collide();
        t_enable();
        t_async();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements) act=%0d exp=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule